// File: doc/BRIEF.md
# Gray-Ordered Threshold DAC Word Sequencer

This block loads the threshold DACs that sit on a group of front-end cards over a single serial link. A one-cycle `start` pulse launches a sequence. For every DAC on every card the block reads a 12-bit setting from an external value table. It packs that setting with a 4-bit ID and shifts the 16-bit result out MSB first, on a serial clock that idles low. A strobe line frames each transfer.

The card/DAC combinations are not visited in binary order. A binary step counter is converted to Gray code, and the Gray value is the ID placed in each word. So only one bit of the ID field changes from one word to the next. The same Gray value, split into a card part and a DAC-slot part, addresses the value table. When all sixteen words have been sent, the block raises `done` for one cycle and waits for the next `start`.

Top module: `thr_dac_seq`

## Requirements
- R1: While reset is applied and after it is released, `dac_strobe`, `dac_sclk`, `dac_mosi`, `done` and `tbl_rd_en` are all low until a `start` pulse arrives.
- R2: Each transfer carries exactly 16 bits, one for each rising edge of `dac_sclk` while `dac_strobe` is high, sent MSB first. Bits 15:4 are the table value and bits 3:0 are the ID.
- R3: The k-th word of a sequence (k = 0..15) carries the ID k XOR (k >> 1). The order therefore begins 0000, 0001, 0011, 0010, 0110, and consecutive IDs differ in exactly one bit.
- R4: For each word the block pulses `tbl_rd_en` for one cycle with `tbl_card` = ID bits 1:0 and `tbl_slot` = ID bits 3:2. It uses the `tbl_data` returned in the following cycle.
- R5: `dac_strobe` rises before the first `dac_sclk` rise of a word and falls one clock after the last `dac_sclk` fall. `dac_sclk` is low whenever `dac_strobe` is low.
- R6: Between two consecutive words `dac_strobe` stays low for at least one clock.
- R7: Each sequence sends exactly 16 words. `done` is high for exactly one cycle, one clock after the last word's strobe falls.
- R8: A `start` pulse that arrives while a sequence is running has no effect: no extra words are sent and no second `done` follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launches a sequence when the block is idle |
| done | output | 1 | One-cycle pulse when the sequence has finished |
| tbl_rd_en | output | 1 | Value table read request |
| tbl_slot | output | 2 | DAC slot part of the table address (ID bits 3:2) |
| tbl_card | output | 2 | Card part of the table address (ID bits 1:0) |
| tbl_data | input | 12 | Table value, valid the cycle after `tbl_rd_en` |
| dac_strobe | output | 1 | High around each 16-bit transfer |
| dac_sclk | output | 1 | Serial clock, idle low |
| dac_mosi | output | 1 | Serial data, stable while `dac_sclk` is high |

## Verification
The bench checks each result at the cycle it is due. The table address is checked in the same cycle that `tbl_rd_en` is high, and the reply is returned by a table model one clock later. A serial bit is captured on the first sample after each `dac_sclk` rise. The full word and its bit count are compared in the first sample in which the strobe is found low. `done` must appear exactly one sample after that strobe-low sample. All outputs are sampled on the falling clock edge, half a period after the register updates, so every comparison sees the settled value of the cycle the model predicts.

// File: rtl/thr_dac_seq_pkg.sv
package thr_dac_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_FETCH = 3'd1,
    ST_LOAD  = 3'd2,
    ST_SEND  = 3'd3,
    ST_GAP   = 3'd4,
    ST_FIN   = 3'd5
  } seq_state_t;
endpackage

// File: rtl/gray_step_ctr.sv
module gray_step_ctr #(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [IDX_W-1:0] gray,
  output logic             last
);
  localparam logic [IDX_W-1:0] LAST_STEP = {IDX_W{1'b1}};

  logic [IDX_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)      cnt_d = '0;
    else if (inc) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign gray = cnt_q ^ (cnt_q >> 1);
  assign last = (cnt_q == LAST_STEP);
endmodule

// File: rtl/dac_word_pack.sv
module dac_word_pack #(
  parameter int VAL_W = 12,
  parameter int IDX_W = 4
) (
  input  logic [VAL_W-1:0]       value,
  input  logic [IDX_W-1:0]       id,
  output logic [VAL_W+IDX_W-1:0] word
);
  assign word = {value, id};
endmodule

// File: rtl/serial_word_tx.sv
module serial_word_tx #(
  parameter int WORD_W   = 16,
  parameter int HALF_DIV = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] word,
  output logic              sclk,
  output logic              mosi,
  output logic              tx_done
);
  localparam int BIT_W = $clog2(WORD_W);
  localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_END = DIV_W'(HALF_DIV - 1);
  localparam logic [BIT_W-1:0] BIT_END = BIT_W'(WORD_W - 1);

  logic [WORD_W-1:0] sreg_q, sreg_d;
  logic [BIT_W-1:0]  bit_q, bit_d;
  logic [DIV_W-1:0]  div_q, div_d;
  logic              sclk_q, sclk_d;
  logic              act_q, act_d;
  logic              fin_q, fin_d;

  always_comb begin
    sreg_d = sreg_q;
    bit_d  = bit_q;
    div_d  = div_q;
    sclk_d = sclk_q;
    act_d  = act_q;
    fin_d  = 1'b0;
    if (load) begin
      sreg_d = word;
      bit_d  = '0;
      div_d  = '0;
      sclk_d = 1'b0;
      act_d  = 1'b1;
    end else if (act_q) begin
      if (div_q == DIV_END) begin
        div_d  = '0;
        sclk_d = ~sclk_q;
        if (sclk_q) begin
          if (bit_q == BIT_END) begin
            act_d = 1'b0;
            fin_d = 1'b1;
          end else begin
            bit_d  = bit_q + 1'b1;
            sreg_d = {sreg_q[WORD_W-2:0], 1'b0};
          end
        end
      end else begin
        div_d = div_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg_q <= '0;
      bit_q  <= '0;
      div_q  <= '0;
      sclk_q <= 1'b0;
      act_q  <= 1'b0;
      fin_q  <= 1'b0;
    end else begin
      sreg_q <= sreg_d;
      bit_q  <= bit_d;
      div_q  <= div_d;
      sclk_q <= sclk_d;
      act_q  <= act_d;
      fin_q  <= fin_d;
    end
  end

  assign sclk    = sclk_q;
  assign mosi    = act_q & sreg_q[WORD_W-1];
  assign tx_done = fin_q;
endmodule

// File: rtl/thr_dac_seq.sv
module thr_dac_seq #(
  parameter int CARD_BITS = 2,
  parameter int SLOT_BITS = 2,
  parameter int VAL_W     = 12,
  parameter int HALF_DIV  = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  output logic                 done,
  output logic                 tbl_rd_en,
  output logic [SLOT_BITS-1:0] tbl_slot,
  output logic [CARD_BITS-1:0] tbl_card,
  input  logic [VAL_W-1:0]     tbl_data,
  output logic                 dac_strobe,
  output logic                 dac_sclk,
  output logic                 dac_mosi
);
  import thr_dac_seq_pkg::*;

  localparam int IDX_W  = CARD_BITS + SLOT_BITS;
  localparam int WORD_W = VAL_W + IDX_W;

  logic [1:0] rsync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_int_n = rsync_q[1];

  seq_state_t       st_q, st_d;
  logic             strobe_q, strobe_d;
  logic             done_q, done_d;
  logic             ctr_clr, ctr_inc, ctr_last;
  logic             sh_load, sh_done;
  logic [IDX_W-1:0] gray_id;
  logic [WORD_W-1:0] tx_word;

  gray_step_ctr #(.IDX_W(IDX_W)) ctr_i (
    .clk   (clk),
    .rst_n (rst_int_n),
    .clr   (ctr_clr),
    .inc   (ctr_inc),
    .gray  (gray_id),
    .last  (ctr_last)
  );

  dac_word_pack #(.VAL_W(VAL_W), .IDX_W(IDX_W)) pack_i (
    .value (tbl_data),
    .id    (gray_id),
    .word  (tx_word)
  );

  serial_word_tx #(.WORD_W(WORD_W), .HALF_DIV(HALF_DIV)) tx_i (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .load    (sh_load),
    .word    (tx_word),
    .sclk    (dac_sclk),
    .mosi    (dac_mosi),
    .tx_done (sh_done)
  );

  always_comb begin
    st_d      = st_q;
    strobe_d  = strobe_q;
    done_d    = 1'b0;
    ctr_clr   = 1'b0;
    ctr_inc   = 1'b0;
    sh_load   = 1'b0;
    tbl_rd_en = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (start) begin
          ctr_clr = 1'b1;
          st_d    = ST_FETCH;
        end
      end
      ST_FETCH: begin
        tbl_rd_en = 1'b1;
        st_d      = ST_LOAD;
      end
      ST_LOAD: begin
        sh_load  = 1'b1;
        strobe_d = 1'b1;
        st_d     = ST_SEND;
      end
      ST_SEND: begin
        if (sh_done) begin
          strobe_d = 1'b0;
          if (ctr_last) begin
            st_d = ST_FIN;
          end else begin
            ctr_inc = 1'b1;
            st_d    = ST_GAP;
          end
        end
      end
      ST_GAP: st_d = ST_FETCH;
      ST_FIN: begin
        done_d = 1'b1;
        st_d   = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      st_q     <= ST_IDLE;
      strobe_q <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      st_q     <= st_d;
      strobe_q <= strobe_d;
      done_q   <= done_d;
    end
  end

  assign tbl_slot   = gray_id[IDX_W-1:CARD_BITS];
  assign tbl_card   = gray_id[CARD_BITS-1:0];
  assign dac_strobe = strobe_q;
  assign done       = done_q;
endmodule

// File: rtl/thr_dac_seq_checker.sv
module thr_dac_seq_checker #(
  parameter int CARD_BITS = 2,
  parameter int SLOT_BITS = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 done,
  input logic                 tbl_rd_en,
  input logic [SLOT_BITS-1:0] tbl_slot,
  input logic [CARD_BITS-1:0] tbl_card,
  input logic                 dac_strobe,
  input logic                 dac_sclk
);
  localparam int IDX_W = CARD_BITS + SLOT_BITS;

  logic [IDX_W-1:0] addr;
  logic [IDX_W-1:0] prev_addr_q;

  assign addr = {tbl_slot, tbl_card};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         prev_addr_q <= '0;
    else if (tbl_rd_en) prev_addr_q <= addr;
  end

  assert_sclk_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !dac_strobe |-> !dac_sclk);

  assert_strobe_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dac_strobe) |=> !dac_strobe);

  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_timing_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> (!dac_strobe && $past(!dac_strobe)));

  assert_read_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_rd_en |=> !tbl_rd_en);

  assert_read_outside_frame_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_rd_en |-> !dac_strobe);

  assert_one_bit_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tbl_rd_en && addr != '0) |-> ($countones(addr ^ prev_addr_q) == 1));
endmodule

bind thr_dac_seq thr_dac_seq_checker #(
  .CARD_BITS(CARD_BITS),
  .SLOT_BITS(SLOT_BITS)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .done       (done),
  .tbl_rd_en  (tbl_rd_en),
  .tbl_slot   (tbl_slot),
  .tbl_card   (tbl_card),
  .dac_strobe (dac_strobe),
  .dac_sclk   (dac_sclk)
);

// File: tb/thr_dac_seq_tb_top.sv
module thr_dac_seq_tb_top;
  logic        clk;
  logic        rst_n;
  logic        start;
  logic        done;
  logic        tbl_rd_en;
  logic [1:0]  tbl_slot;
  logic [1:0]  tbl_card;
  logic [11:0] tbl_data;
  logic        dac_strobe;
  logic        dac_sclk;
  logic        dac_mosi;

  thr_dac_seq dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .done       (done),
    .tbl_rd_en  (tbl_rd_en),
    .tbl_slot   (tbl_slot),
    .tbl_card   (tbl_card),
    .tbl_data   (tbl_data),
    .dac_strobe (dac_strobe),
    .dac_sclk   (dac_sclk),
    .dac_mosi   (dac_mosi)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  logic [11:0] table_mem [16];
  logic [15:0] exp_word  [16];

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // table model: one cycle of read latency
  always @(posedge clk) begin
    if (tbl_rd_en) tbl_data <= table_mem[{tbl_slot, tbl_card}];
  end

  // monitor state
  bit          mon_en = 0;
  bit          prev_strobe = 0;
  bit          prev_sclk = 0;
  bit          after_fall = 0;
  logic [15:0] cap = '0;
  int          nbits = 0;
  int          widx = 0;
  int          ridx = 0;
  int          since_fall = 100;
  int          done_cnt = 0;
  int          strobe_rises = 0;
  int          prev_id = 0;

  always @(negedge clk) begin
    if (mon_en) begin
      since_fall++;
      check(dac_strobe || !dac_sclk, "R5", "sclk high while strobe low", dac_sclk, 0);
      if (after_fall)
        check(!dac_strobe, "R6", "strobe gap after word", dac_strobe, 0);
      after_fall = 0;
      if (dac_strobe && !prev_strobe) begin
        check(!dac_sclk, "R5", "sclk low at strobe rise", dac_sclk, 0);
        nbits = 0;
        cap = '0;
        strobe_rises++;
      end
      if (dac_strobe && dac_sclk && !prev_sclk) begin
        cap = {cap[14:0], dac_mosi};
        nbits++;
      end
      if (!dac_strobe && prev_strobe) begin
        check(!prev_sclk, "R5", "sclk low before strobe fall", prev_sclk, 0);
        check(nbits == 16, "R2", "bit count per word", nbits, 16);
        if (widx < 16) begin
          check(cap == exp_word[widx], "R2", "word content", cap, exp_word[widx]);
          check(int'(cap[3:0]) == (widx ^ (widx >> 1)), "R3", "ID order", cap[3:0],
                widx ^ (widx >> 1));
          if (widx > 0)
            check($countones(cap[3:0] ^ prev_id[3:0]) == 1, "R3", "one-bit ID step",
                  cap[3:0], prev_id);
          prev_id = int'(cap[3:0]);
        end else begin
          check(0, "R8", "extra word sent", widx, 15);
        end
        widx++;
        since_fall = 0;
        after_fall = 1;
      end
      if (tbl_rd_en) begin
        check(int'({tbl_slot, tbl_card}) == (ridx ^ (ridx >> 1)), "R4", "table address",
              {tbl_slot, tbl_card}, ridx ^ (ridx >> 1));
        ridx++;
      end
      if (done) begin
        check(since_fall == 1, "R7", "done delay after strobe fall", since_fall, 1);
        check(widx == 16, "R7", "words before done", widx, 16);
        done_cnt++;
      end
      prev_strobe = dac_strobe;
      prev_sclk = dac_sclk;
    end
  end

  task automatic fill_table(input int salt);
    for (int a = 0; a < 16; a++)
      table_mem[a] = 12'((a * 2531 + salt * 977 + 1) & 12'hFFF);
    for (int k = 0; k < 16; k++) begin
      int g = k ^ (k >> 1);
      exp_word[k] = {table_mem[g], 4'(g)};
    end
  endtask

  task automatic pulse_start();
    @(posedge clk); #1 start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
  endtask

  task automatic run_seq(input int salt, input bit poke);
    int d0;
    fill_table(salt);
    widx = 0;
    ridx = 0;
    d0 = done_cnt;
    pulse_start();
    if (poke) begin
      repeat (150) @(posedge clk);
      pulse_start();            // R8: ignored mid-sequence
      repeat (400) @(posedge clk);
      pulse_start();
    end
    while (done_cnt == d0) @(posedge clk);
    repeat (200) @(posedge clk);
    @(negedge clk);
    check(widx == 16, "R7", "words in sequence", widx, 16);
    check(ridx == 16, "R4", "table reads in sequence", ridx, 16);
    check(done_cnt == d0 + 1, "R8", "single done per sequence", done_cnt, d0 + 1);
    check(!dac_strobe && !tbl_rd_en, "R8", "idle after sequence",
          {dac_strobe, tbl_rd_en}, 0);
  endtask

  // watchdog
  initial begin
    while (cycles < 100000) begin
      @(posedge clk);
      cycles++;
    end
    failures++;
    checks++;
    $display("FAIL watchdog expired actual=%0d expected<100000", cycles);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    start = 1'b0;
    tbl_data = '0;
    fill_table(0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check({dac_strobe, dac_sclk, dac_mosi, done, tbl_rd_en} == 5'b0, "R1",
          "outputs in reset", {dac_strobe, dac_sclk, dac_mosi, done, tbl_rd_en}, 0);
    #1 rst_n = 1'b1;
    repeat (10) @(posedge clk);
    @(negedge clk);
    check({dac_strobe, dac_sclk, dac_mosi, done, tbl_rd_en} == 5'b0, "R1",
          "outputs idle after reset", {dac_strobe, dac_sclk, dac_mosi, done, tbl_rd_en}, 0);
    mon_en = 1;
    run_seq(1, 1'b1);
    run_seq(2, 1'b0);
    run_seq(3, 1'b0);
    check(strobe_rises == 48, "R7", "total words over three runs", strobe_rises, 48);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule